// File: doc/BRIEF.md
# Linked-List DMA Channel Sequencer

This block is the transfer engine of a multi-channel DMA controller. It holds five 32-bit registers per channel (source address, destination address, link address, control, configuration). A single scan pointer visits the channels in ascending index order. A channel is served when it is enabled, not halted, has a nonzero remaining count and its flow-control mode is satisfied by the peripheral request lines. Serving a channel means one element is read from the source and written to the destination over a single-outstanding memory master port. The addresses then step, and the remaining count is decremented in place.

When the count of a channel reaches zero, one of two things happens. If its link address is nonzero, the engine reloads the channel from a four-word descriptor in memory. If the link address is zero, the engine clears the channel's enable bit. A completion can also raise a sticky per-channel terminal-count flag. A flow-control mode code the engine does not support raises a sticky per-channel error flag instead of moving data. A host port writes and reads the channel registers, and pulse inputs clear the flags.

Top module: `dma_ll_seq`

## Requirements
- R1: Nothing is fetched while `glb_en` is 0, and while it is 0 the scan pointer returns to channel 0.
- R2: A channel is eligible only when configuration bit 0 (enable) is 1 and configuration bit 18 (halt) is 0. A halted channel moves no data.
- R3: The flow mode is configuration bits [13:11]. Mode 0 needs no request. Mode 1 needs the destination request. Mode 2 needs the source request. Mode 3 needs both. The source peripheral id is configuration bits [5:1] and the destination id is bits [10:6]. A request line counts as active when either `req_single` or `req_burst` has that bit set.
- R4: A live channel with a flow mode of 4 to 7 moves no data and sets its bit in `err_raw`. `err_clr` clears that bit.
- R5: A channel whose count field (control bits [11:0]) is zero is skipped and stays enabled.
- R6: One element is a read of 1<<code bytes at the source address (code = control bits [20:18]), followed by a write of those bytes at the destination address (code = control bits [23:21]). Data sits in the low bytes of the data buses, little-endian, and `mem_size` carries the code.
- R7: After each element, the source address advances by the element width when control bit 26 is set, and the destination address advances by the element width when control bit 27 is set. Otherwise each address holds.
- R8: After each element, the count field holds the old value minus one, and control bits [31:12] are unchanged.
- R9: On completion with a nonzero link address L, four word reads follow in this order: L+0 into source, L+4 into destination, L+12 into control, L+8 into link. On completion with a zero link address, configuration bit 0 is cleared.
- R10: On completion, if control bit 31 of the finishing control word is 1, the channel's bit in `tc_raw` is set. `tc_clr` clears that bit.
- R11: The engine keeps serving one channel until it is no longer eligible, then moves to the next higher index, wrapping to 0.
- R12: The memory request holds valid, address, direction and size stable until `mem_ready` is seen, and only one request is outstanding at a time.
- R13: Host field codes are 0 source, 1 destination, 2 link, 3 control, 4 configuration. A host write replaces that register, and `rd_data` returns the selected register of `rd_ch` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global engine enable |
| req_single | input | 32 | Single-transfer peripheral requests |
| req_burst | input | 32 | Burst peripheral requests |
| host_we | input | 1 | Host register write strobe |
| host_ch | input | CW | Channel for host write |
| host_fld | input | 3 | Field code for host write |
| host_wdata | input | 32 | Host write data |
| rd_ch | input | CW | Channel for read-back |
| rd_fld | input | 3 | Field code for read-back |
| rd_data | output | 32 | Selected register value |
| tc_clr | input | NCH | Terminal-count flag clear pulses |
| err_clr | input | NCH | Error flag clear pulses |
| tc_raw | output | NCH | Sticky terminal-count flags |
| err_raw | output | NCH | Sticky unsupported-mode flags |
| chan_on | output | NCH | Enable bit of each channel |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 3 | Size code, bytes = 1<<code |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts / returns data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |

## Verification
A host write is visible on `rd_data` from the clock edge that takes it. An element's address and count updates, a cleared enable bit, and a flag set all land on the edge of the write handshake. A descriptor word lands on the edge of its read handshake. Each new request goes out one scan cycle after the engine reaches the channel, and the memory model inserts zero to two wait cycles per request. The checks therefore never sample at a fixed offset from a stimulus. Instead they sample at a falling edge after polling `chan_on` until the channel drops, or after a quiet window of several tens of cycles for stimuli that must not move data. Request order is taken from a log the memory model keeps at each handshake.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;

    localparam int REQ_N = 32;
    localparam int CNT_W = 12;

    // field code used by the host port
    localparam logic [2:0] FLD_SRC  = 3'd0;
    localparam logic [2:0] FLD_DST  = 3'd1;
    localparam logic [2:0] FLD_LINK = 3'd2;
    localparam logic [2:0] FLD_CTRL = 3'd3;
    localparam logic [2:0] FLD_CFG  = 3'd4;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] link;
        logic [31:0] ctrl;
        logic [31:0] cfg;
    } chan_t;

    typedef enum logic [1:0] {
        S_SCAN,
        S_RD,
        S_WR,
        S_LL
    } mv_st_e;

    function automatic logic [31:0] elem_bytes(input logic [2:0] code);
        return 32'd1 << code;
    endfunction

    // descriptor words are fetched in the order +0, +4, +12, +8
    function automatic logic [31:0] link_off(input logic [1:0] step);
        case (step)
            2'd0:    return 32'd0;
            2'd1:    return 32'd4;
            2'd2:    return 32'd12;
            default: return 32'd8;
        endcase
    endfunction

    function automatic logic [31:0] field_of(input chan_t c, input logic [2:0] fld);
        case (fld)
            FLD_SRC:  return c.src;
            FLD_DST:  return c.dst;
            FLD_LINK: return c.link;
            FLD_CTRL: return c.ctrl;
            FLD_CFG:  return c.cfg;
            default:  return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/dma_ll_gate.sv
module dma_ll_gate
    import dma_ll_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                glb_en,
    input  chan_t [NCH-1:0]     chans,
    input  logic [REQ_N-1:0]    req_single,
    input  logic [REQ_N-1:0]    req_burst,
    output logic [NCH-1:0]      elig,
    output logic [NCH-1:0]      bad
);

    logic [REQ_N-1:0] req_any;
    assign req_any = req_single | req_burst;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic       live;
        logic       sreq;
        logic       dreq;
        logic       ok;
        logic [2:0] mode;

        assign mode = chans[g].cfg[13:11];
        assign sreq = req_any[chans[g].cfg[5:1]];
        assign dreq = req_any[chans[g].cfg[10:6]];
        assign live = glb_en & chans[g].cfg[0] & ~chans[g].cfg[18];

        always_comb begin
            case (mode)
                3'd0:    ok = 1'b1;
                3'd1:    ok = dreq;
                3'd2:    ok = sreq;
                3'd3:    ok = sreq & dreq;
                default: ok = 1'b0;
            endcase
        end

        assign elig[g] = live & ok & (chans[g].ctrl[CNT_W-1:0] != '0);
        assign bad[g]  = live & mode[2];
    end

endmodule

// File: rtl/dma_ll_bank.sv
module dma_ll_bank
    import dma_ll_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            host_we,
    input  logic [CW-1:0]   host_ch,
    input  logic [2:0]      host_fld,
    input  logic [31:0]     host_wdata,
    input  logic            eng_we,
    input  logic [CW-1:0]   eng_ch,
    input  chan_t           eng_val,
    input  logic [NCH-1:0]  tc_set,
    input  logic [NCH-1:0]  err_set,
    input  logic [NCH-1:0]  tc_clr,
    input  logic [NCH-1:0]  err_clr,
    output chan_t [NCH-1:0] chans,
    output logic [NCH-1:0]  tc_raw,
    output logic [NCH-1:0]  err_raw
);

    always_ff @(posedge clk) begin
        if (rst) begin
            chans   <= '0;
            tc_raw  <= '0;
            err_raw <= '0;
        end else begin
            tc_raw  <= (tc_raw & ~tc_clr) | tc_set;
            err_raw <= (err_raw & ~err_clr) | err_set;
            for (int i = 0; i < NCH; i++) begin
                if (host_we && host_ch == CW'(i)) begin
                    case (host_fld)
                        FLD_SRC:  chans[i].src  <= host_wdata;
                        FLD_DST:  chans[i].dst  <= host_wdata;
                        FLD_LINK: chans[i].link <= host_wdata;
                        FLD_CTRL: chans[i].ctrl <= host_wdata;
                        FLD_CFG:  chans[i].cfg  <= host_wdata;
                        default:  ;
                    endcase
                end else if (eng_we && eng_ch == CW'(i)) begin
                    chans[i] <= eng_val;
                end
            end
        end
    end

    // R10: a terminal-count flag rises only from an engine completion
    a_r10_tc_source : assert property (@(posedge clk) disable iff (rst)
        ((tc_raw & ~$past(tc_raw)) != '0) |-> ($past(tc_set) != '0));

endmodule

// File: rtl/dma_ll_mover.sv
module dma_ll_mover
    import dma_ll_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           glb_en,
    input  logic [NCH-1:0] elig,
    input  logic [NCH-1:0] bad,
    input  chan_t          ch_in,
    input  logic           mem_ready,
    input  logic [31:0]    mem_rdata,
    output logic           mem_valid,
    output logic           mem_write,
    output logic [31:0]    mem_addr,
    output logic [31:0]    mem_wdata,
    output logic [2:0]     mem_size,
    output logic           eng_we,
    output logic [CW-1:0]  eng_ch,
    output chan_t          eng_val,
    output logic [NCH-1:0] tc_set,
    output logic [NCH-1:0] err_set
);

    mv_st_e            st;
    logic [CW-1:0]     cur;
    logic [31:0]       hold;
    logic [31:0]       lbase;
    logic [1:0]        step;
    logic [CNT_W-1:0]  left;
    logic              last;
    logic [CW-1:0]     cur_nxt;

    assign left    = ch_in.ctrl[CNT_W-1:0] - 1'b1;
    assign last    = (left == '0);
    assign cur_nxt = (cur == CW'(NCH - 1)) ? '0 : cur + 1'b1;
    assign eng_ch  = cur;

    always_comb begin
        mem_valid = (st != S_SCAN);
        mem_write = (st == S_WR);
        mem_wdata = hold;
        case (st)
            S_RD:    begin mem_addr = ch_in.src;            mem_size = ch_in.ctrl[20:18]; end
            S_WR:    begin mem_addr = ch_in.dst;            mem_size = ch_in.ctrl[23:21]; end
            S_LL:    begin mem_addr = lbase + link_off(step); mem_size = 3'd2;           end
            default: begin mem_addr = '0;                   mem_size = 3'd0;              end
        endcase
    end

    always_comb begin
        eng_we  = 1'b0;
        eng_val = ch_in;
        tc_set  = '0;
        err_set = '0;
        case (st)
            S_SCAN: begin
                if (glb_en && !elig[cur] && bad[cur])
                    err_set[cur] = 1'b1;
            end
            S_WR: begin
                if (mem_ready) begin
                    eng_we = 1'b1;
                    if (ch_in.ctrl[26])
                        eng_val.src = ch_in.src + elem_bytes(ch_in.ctrl[20:18]);
                    if (ch_in.ctrl[27])
                        eng_val.dst = ch_in.dst + elem_bytes(ch_in.ctrl[23:21]);
                    eng_val.ctrl[CNT_W-1:0] = left;
                    if (last) begin
                        if (ch_in.link == '0)
                            eng_val.cfg[0] = 1'b0;
                        if (ch_in.ctrl[31])
                            tc_set[cur] = 1'b1;
                    end
                end
            end
            S_LL: begin
                if (mem_ready) begin
                    eng_we = 1'b1;
                    case (step)
                        2'd0:    eng_val.src  = mem_rdata;
                        2'd1:    eng_val.dst  = mem_rdata;
                        2'd2:    eng_val.ctrl = mem_rdata;
                        default: eng_val.link = mem_rdata;
                    endcase
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_SCAN;
            cur   <= '0;
            hold  <= '0;
            lbase <= '0;
            step  <= '0;
        end else begin
            case (st)
                S_SCAN: begin
                    if (!glb_en)
                        cur <= '0;
                    else if (elig[cur])
                        st <= S_RD;
                    else
                        cur <= cur_nxt;
                end
                S_RD: begin
                    if (mem_ready) begin
                        hold <= mem_rdata;
                        st   <= S_WR;
                    end
                end
                S_WR: begin
                    if (mem_ready) begin
                        if (last && ch_in.link != '0) begin
                            lbase <= ch_in.link;
                            step  <= '0;
                            st    <= S_LL;
                        end else begin
                            st <= S_SCAN;
                        end
                    end
                end
                S_LL: begin
                    if (mem_ready) begin
                        step <= step + 1'b1;
                        if (step == 2'd3)
                            st <= S_SCAN;
                    end
                end
                default: st <= S_SCAN;
            endcase
        end
    end

    // R11: after a non-final element the same channel is looked at again
    a_r11_hold_channel : assert property (@(posedge clk) disable iff (rst)
        (st == S_WR && mem_ready && !last) |=> (st == S_SCAN && $stable(cur)));

    // R4: an error flag is only raised while scanning, never mid-transfer
    a_r4_err_in_scan : assert property (@(posedge clk) disable iff (rst)
        (err_set != '0) |-> (st == S_SCAN && !mem_valid));

endmodule

// File: rtl/dma_ll_seq.sv
module dma_ll_seq
    import dma_ll_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             glb_en,
    input  logic [REQ_N-1:0] req_single,
    input  logic [REQ_N-1:0] req_burst,
    input  logic             host_we,
    input  logic [CW-1:0]    host_ch,
    input  logic [2:0]       host_fld,
    input  logic [31:0]      host_wdata,
    input  logic [CW-1:0]    rd_ch,
    input  logic [2:0]       rd_fld,
    output logic [31:0]      rd_data,
    input  logic [NCH-1:0]   tc_clr,
    input  logic [NCH-1:0]   err_clr,
    output logic [NCH-1:0]   tc_raw,
    output logic [NCH-1:0]   err_raw,
    output logic [NCH-1:0]   chan_on,
    output logic             mem_valid,
    output logic             mem_write,
    output logic [31:0]      mem_addr,
    output logic [2:0]       mem_size,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ready,
    input  logic [31:0]      mem_rdata
);

    chan_t [NCH-1:0] chans;
    logic [NCH-1:0]  elig;
    logic [NCH-1:0]  bad;
    logic            eng_we;
    logic [CW-1:0]   eng_ch;
    chan_t           eng_val;
    chan_t           ch_in;
    logic [NCH-1:0]  tc_set;
    logic [NCH-1:0]  err_set;

    assign ch_in   = chans[eng_ch];
    assign rd_data = field_of(chans[rd_ch], rd_fld);

    always_comb begin
        for (int i = 0; i < NCH; i++)
            chan_on[i] = chans[i].cfg[0];
    end

    dma_ll_gate #(.NCH(NCH)) u_gate (
        .glb_en     (glb_en),
        .chans      (chans),
        .req_single (req_single),
        .req_burst  (req_burst),
        .elig       (elig),
        .bad        (bad)
    );

    dma_ll_bank #(.NCH(NCH), .CW(CW)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_ch    (host_ch),
        .host_fld   (host_fld),
        .host_wdata (host_wdata),
        .eng_we     (eng_we),
        .eng_ch     (eng_ch),
        .eng_val    (eng_val),
        .tc_set     (tc_set),
        .err_set    (err_set),
        .tc_clr     (tc_clr),
        .err_clr    (err_clr),
        .chans      (chans),
        .tc_raw     (tc_raw),
        .err_raw    (err_raw)
    );

    dma_ll_mover #(.NCH(NCH), .CW(CW)) u_mover (
        .clk        (clk),
        .rst        (rst),
        .glb_en     (glb_en),
        .elig       (elig),
        .bad        (bad),
        .ch_in      (ch_in),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .mem_valid  (mem_valid),
        .mem_write  (mem_write),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_size   (mem_size),
        .eng_we     (eng_we),
        .eng_ch     (eng_ch),
        .eng_val    (eng_val),
        .tc_set     (tc_set),
        .err_set    (err_set)
    );

    // R1: a new request may only start after a cycle with the engine enabled
    a_r1_global_gate : assert property (@(posedge clk) disable iff (rst)
        $rose(mem_valid) |-> $past(glb_en));

    // R2: a transfer only starts on an enabled channel
    a_r2_start_enabled : assert property (@(posedge clk) disable iff (rst)
        $rose(mem_valid) |-> chan_on[eng_ch]);

    // R12: a pending request is held unchanged
    a_r12_req_stable : assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_write) && $stable(mem_size)));

    // R8: an element write decrements the count and keeps the upper control bits
    a_r8_count_step : assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write && mem_ready && !host_we) |=>
        (chans[$past(eng_ch)].ctrl[31:12] == $past(chans[eng_ch].ctrl[31:12]) &&
         chans[$past(eng_ch)].ctrl[11:0] == $past(chans[eng_ch].ctrl[11:0]) - 12'd1));

endmodule

// File: tb/dma_ll_seq_tb.sv
module dma_ll_seq_tb;

    localparam int NCH = 4;
    localparam int CW  = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              glb_en = 1'b0;
    logic [31:0]       req_single = '0;
    logic [31:0]       req_burst = '0;
    logic              host_we = 1'b0;
    logic [CW-1:0]     host_ch = '0;
    logic [2:0]        host_fld = '0;
    logic [31:0]       host_wdata = '0;
    logic [CW-1:0]     rd_ch = '0;
    logic [2:0]        rd_fld = '0;
    logic [31:0]       rd_data;
    logic [NCH-1:0]    tc_clr = '0;
    logic [NCH-1:0]    err_clr = '0;
    logic [NCH-1:0]    tc_raw;
    logic [NCH-1:0]    err_raw;
    logic [NCH-1:0]    chan_on;
    logic              mem_valid;
    logic              mem_write;
    logic [31:0]       mem_addr;
    logic [2:0]        mem_size;
    logic [31:0]       mem_wdata;
    logic              mem_ready = 1'b0;
    logic [31:0]       mem_rdata = '0;

    dma_ll_seq #(.NCH(NCH)) u_dut (.*);

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [7:0]  mem  [0:4095];
    logic [7:0]  emem [0:4095];
    logic [31:0] rlog [0:255];
    logic [31:0] wlog [0:255];
    int          rn = 0;
    int          wn = 0;
    int          nreq = 0;
    int          dly = 0;
    int          cyc = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // memory model: serves one request at a falling edge, 0..2 wait cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
                dly = int'($urandom % 3);
            end else if (mem_valid && !rst) begin
                if (dly == 0) begin
                    int n;
                    n = 1 << mem_size;
                    if (mem_write) begin
                        for (int k = 0; k < n; k++)
                            mem[(mem_addr[11:0] + 12'(k))] = mem_wdata[8*k +: 8];
                        if (wn < 256) wlog[wn] = mem_addr;
                        wn++;
                    end else begin
                        mem_rdata = '0;
                        for (int k = 0; k < n; k++)
                            mem_rdata[8*k +: 8] = mem[(mem_addr[11:0] + 12'(k))];
                        if (rn < 256) rlog[rn] = mem_addr;
                        rn++;
                    end
                    nreq++;
                    mem_ready = 1'b1;
                end else begin
                    dly--;
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                summary();
            end
        end
    end

    function automatic logic [31:0] mkctrl(input int cnt, input int wc, input bit si,
                                           input bit di, input bit tc);
        return 32'(cnt) | (32'(wc) << 18) | (32'(wc) << 21) | (32'(si) << 26)
             | (32'(di) << 27) | (32'(tc) << 31) | 32'h0000_5000;
    endfunction

    function automatic logic [31:0] mkcfg(input bit en, input bit halt, input int mode,
                                          input int sid, input int did);
        return 32'(en) | (32'(sid) << 1) | (32'(did) << 6) | (32'(mode) << 11)
             | (32'(halt) << 18);
    endfunction

    task automatic hwr(input int ch, input int fld, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_ch = CW'(ch); host_fld = 3'(fld); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hrd(input int ch, input int fld, output logic [31:0] d);
        @(negedge clk);
        rd_ch = CW'(ch); rd_fld = 3'(fld);
        #1 d = rd_data;
    endtask

    task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] l, input logic [31:0] c, input logic [31:0] f);
        hwr(ch, 0, s); hwr(ch, 1, d); hwr(ch, 2, l); hwr(ch, 3, c); hwr(ch, 4, f);
    endtask

    task automatic wait_off(input int ch);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!chan_on[ch]) return;
        end
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[a + k] = v[8*k +: 8];
    endtask

    function automatic logic [31:0] get32(input int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    task automatic quiet(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int base;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("R13 reset chan_on", 32'(chan_on), 0);
        chk("R10 reset tc_raw", 32'(tc_raw), 0);
        chk("R12 reset mem_valid", 32'(mem_valid), 0);
        hrd(2, 3, v); chk("R13 reset ctrl", v, 0);

        // R13 register write/read-back
        hwr(3, 1, 32'hCAFE_0123);
        hrd(3, 1, v); chk("R13 host write dst", v, 32'hCAFE_0123);
        hwr(3, 1, 32'h0);

        // R1: global enable off, nothing moves
        setup(0, 32'h100, 32'h200, 0, mkctrl(4, 2, 1, 1, 1), mkcfg(1, 0, 0, 0, 0));
        base = nreq; quiet(40);
        chk("R1 no request while glb_en=0", nreq, base);

        // R6 R7 R8 R10: word copy with both increments
        glb_en = 1'b1;
        wait_off(0);
        glb_en = 1'b0; quiet(4);
        for (int i = 0; i < 4; i++)
            chk("R6 word copied", get32(32'h200 + 4*i), get32(32'h100 + 4*i));
        hrd(0, 0, v); chk("R7 src advanced", v, 32'h110);
        hrd(0, 1, v); chk("R7 dst advanced", v, 32'h210);
        hrd(0, 3, v); chk("R8 count zero, upper kept", v, mkctrl(0, 2, 1, 1, 1));
        chk("R9 zero link clears enable", 32'(chan_on[0]), 0);
        chk("R10 tc flag set", 32'(tc_raw), 32'h1);
        @(negedge clk); tc_clr = 4'h1; @(negedge clk); tc_clr = '0; @(negedge clk);
        chk("R10 tc flag cleared", 32'(tc_raw), 0);

        // R2 halted channel
        setup(1, 32'h100, 32'h600, 0, mkctrl(3, 2, 1, 1, 0), mkcfg(1, 1, 0, 0, 0));
        glb_en = 1'b1; base = nreq; quiet(40);
        chk("R2 halted channel idle", nreq, base);
        hrd(1, 3, v); chk("R2 halted count kept", v[11:0], 3);
        glb_en = 1'b0; hwr(1, 4, 0);

        // R5 zero count
        setup(2, 32'h100, 32'h600, 0, mkctrl(0, 2, 1, 1, 0), mkcfg(1, 0, 0, 0, 0));
        glb_en = 1'b1; base = nreq; quiet(40);
        chk("R5 zero count skipped", nreq, base);
        chk("R5 still enabled", 32'(chan_on[2]), 1);
        glb_en = 1'b0; hwr(2, 4, 0);

        // R4 unsupported flow mode
        setup(3, 32'h100, 32'h600, 0, mkctrl(2, 2, 1, 1, 0), mkcfg(1, 0, 5, 0, 0));
        glb_en = 1'b1; base = nreq; quiet(40);
        chk("R4 no transfer in mode 5", nreq, base);
        chk("R4 error flag", 32'(err_raw), 32'h8);
        glb_en = 1'b0; hwr(3, 4, 0);
        @(negedge clk); err_clr = 4'h8; @(negedge clk); err_clr = '0; @(negedge clk);
        chk("R4 error cleared", 32'(err_raw), 0);

        // R3 mode 1 (dest request id 5), src id 9
        setup(1, 32'h100, 32'h640, 0, mkctrl(2, 2, 1, 1, 0), mkcfg(1, 0, 1, 9, 5));
        glb_en = 1'b1; base = nreq; quiet(30);
        chk("R3 mode1 no request", nreq, base);
        req_single[9] = 1'b1; quiet(30);
        chk("R3 mode1 src request ignored", nreq, base);
        req_burst[5] = 1'b1;
        wait_off(1);
        chk("R3 mode1 done on burst dest request", 32'(chan_on[1]), 0);
        glb_en = 1'b0; req_single = '0; req_burst = '0; quiet(4);
        // mode 3
        setup(1, 32'h100, 32'h660, 0, mkctrl(1, 2, 1, 1, 0), mkcfg(1, 0, 3, 9, 5));
        glb_en = 1'b1; req_single[9] = 1'b1; base = nreq; quiet(30);
        chk("R3 mode3 needs both", nreq, base);
        req_single[5] = 1'b1;
        wait_off(1);
        chk("R3 mode3 done", 32'(chan_on[1]), 0);
        glb_en = 1'b0; req_single = '0; quiet(4);
        // mode 2
        setup(1, 32'h100, 32'h680, 0, mkctrl(1, 2, 1, 1, 0), mkcfg(1, 0, 2, 9, 5));
        glb_en = 1'b1; req_burst[9] = 1'b1;
        wait_off(1);
        chk("R3 mode2 src request", 32'(chan_on[1]), 0);
        glb_en = 1'b0; req_burst = '0; quiet(4);

        // R7 byte width, fixed source, incrementing destination
        setup(2, 32'h050, 32'h700, 0, mkctrl(3, 0, 0, 1, 0), mkcfg(1, 0, 0, 0, 0));
        glb_en = 1'b1; wait_off(2); glb_en = 1'b0; quiet(4);
        for (int i = 0; i < 3; i++) chk("R7 byte fixed source", 32'(mem[32'h700 + i]), 32'(mem[32'h050]));
        hrd(2, 0, v); chk("R7 src held", v, 32'h050);
        hrd(2, 1, v); chk("R7 dst by one", v, 32'h703);

        // R9 linked reload
        put32(32'h300, 32'h140); put32(32'h304, 32'h240);
        put32(32'h308, 32'h0);   put32(32'h30C, mkctrl(3, 2, 1, 1, 1));
        setup(0, 32'h100, 32'h200, 32'h300, mkctrl(2, 2, 1, 1, 0), mkcfg(1, 0, 0, 0, 0));
        rn = 0;
        glb_en = 1'b1; wait_off(0); glb_en = 1'b0; quiet(4);
        chk("R9 fetch +0", rlog[2], 32'h300);
        chk("R9 fetch +4", rlog[3], 32'h304);
        chk("R9 fetch +12", rlog[4], 32'h30C);
        chk("R9 fetch +8", rlog[5], 32'h308);
        chk("R9 first segment", get32(32'h204), get32(32'h104));
        chk("R9 second segment", get32(32'h248), get32(32'h148));
        hrd(0, 0, v); chk("R9 reloaded src advanced", v, 32'h14C);
        chk("R10 tc from reloaded word", 32'(tc_raw), 32'h1);
        @(negedge clk); tc_clr = 4'h1; @(negedge clk); tc_clr = '0;

        // R11 order: channel 0 finishes before channel 1
        setup(1, 32'h180, 32'h780, 0, mkctrl(2, 2, 1, 1, 0), mkcfg(1, 0, 0, 0, 0));
        setup(0, 32'h1C0, 32'h7C0, 0, mkctrl(2, 2, 1, 1, 0), mkcfg(1, 0, 0, 0, 0));
        wn = 0;
        glb_en = 1'b1; wait_off(1); wait_off(0); glb_en = 1'b0; quiet(4);
        chk("R11 first write ch0", wlog[0], 32'h7C0);
        chk("R11 second write ch0", wlog[1], 32'h7C4);
        chk("R11 then ch1", wlog[2], 32'h780);
        chk("R11 then ch1 next", wlog[3], 32'h784);

        // random element copies against a bench model (R6 R7 R8)
        for (int it = 0; it < 6; it++) begin
            int cnt, wc, w, ch;
            bit si, di;
            logic [31:0] s, d, es, ed;
            int bad_bytes;
            cnt = 1 + int'($urandom % 6); wc = int'($urandom % 3); w = 1 << wc;
            si = 1'($urandom); di = 1'($urandom); ch = it % NCH;
            s = 32'($urandom % 200); d = 32'h800 + 32'(it * 64);
            for (int i = 0; i < 4096; i++) emem[i] = mem[i];
            es = s; ed = d;
            for (int n = 0; n < cnt; n++) begin
                for (int k = 0; k < w; k++) emem[ed + k] = emem[es + k];
                if (si) es = es + w;
                if (di) ed = ed + w;
            end
            setup(ch, s, d, 0, mkctrl(cnt, wc, si, di, 0), mkcfg(1, 0, 0, 0, 0));
            glb_en = 1'b1; wait_off(ch); glb_en = 1'b0; quiet(4);
            bad_bytes = 0;
            for (int i = 0; i < 64; i++) if (mem[d + i] !== emem[d + i]) bad_bytes++;
            chk("R6 random copy bytes mismatched", bad_bytes, 0);
            hrd(ch, 0, v); chk("R7 random src", v, es);
            hrd(ch, 1, v); chk("R7 random dst", v, ed);
            hrd(ch, 3, v); chk("R8 random ctrl", v, mkctrl(0, wc, si, di, 0));
        end
        chk("R10 no flag without bit 31", 32'(tc_raw), 0);

        summary();
    end

endmodule